// File: doc/BRIEF.md
# PHY Control-Register Bus Master

This block runs single read or write transactions on a slow PHY configuration bus. The bus has no free-running clock. The master produces the bus clock as discrete pulses and drives a select line, a read strobe, a write strobe, a 16-bit address field and a 16-bit write-data field. It samples an acknowledge line and a 16-bit read-data field coming back from the PHY.

The requester side has one start pulse that carries a direction bit, an address and write data. The block reports busy while the access runs. It ends with a one-cycle done pulse, and with it a timeout flag and, on reads, the captured read data.

Every access begins by flushing the PHY side with a fixed run of clock pulses. It then places the address and data, strobes the transaction with one clock pulse, and polls the acknowledge line. After each failed poll it sends one more clock pulse, and it stops trying after a bounded number of polls.

Top module: `phy_cr_master`

## Requirements
- R1: Each bus clock pulse holds `cr_clk_o` high for exactly HI_CYC system cycles and then low for at least LO_CYC cycles. `cr_clk_o` stays low whenever `busy_o` is low.
- R2: Each access starts with exactly FLUSH_PULSES (default 100) clock pulses. Select, address, data and both enables keep their values until that run is complete.
- R3: After the flush, `cr_sel_o` rises and `cr_addr_o` carries the requested address. The address holds until the access ends. Select falls in the cycle that done pulses.
- R4: On a write, `cr_wdata_o` carries the write data at least one cycle before `cr_wr_en_o` rises. On a read, `cr_wdata_o` is zero.
- R5: The launch raises `cr_wr_en_o` (write, `write_i`=1) or `cr_rd_en_o` (read, `write_i`=0) for exactly one clock pulse. The two enables then fall together. They are never high at the same time, and neither is high without select.
- R6: Ack is polled after the launch. If ack is low, one clock pulse and POLL_GAP idle cycles follow, and then the block polls again. At most MAX_POLLS (default 10) polls are made. A successful access therefore emits FLUSH_PULSES + 1 + (failed polls) clock pulses.
- R7: If ack is low on all MAX_POLLS polls, the access ends with `timeout_o` high and FLUSH_PULSES + MAX_POLLS clock pulses in total. No pulse follows the last failed poll.
- R8: On a read, `rdata_o` captures `cr_rdata_i` at the poll that sees ack. It keeps that value through writes and timed-out reads.
- R9: `done_o` is a single-cycle pulse at the end of every access. `busy_o` is high from the cycle after start until done, and falls in the done cycle. `timeout_o` is only ever high together with `done_o`.
- R10: A start request made while busy is ignored. The running access keeps its address and direction, and no second access follows.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Access request, one cycle |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle end-of-access pulse |
| timeout_o | output | 1 | No ack seen; valid with done |
| rdata_o | output | DATA_W | Last successful read result |
| cr_clk_o | output | 1 | Pulsed bus clock |
| cr_sel_o | output | 1 | Bus select |
| cr_rd_en_o | output | 1 | Read strobe |
| cr_wr_en_o | output | 1 | Write strobe |
| cr_addr_o | output | ADDR_W | Bus address field |
| cr_wdata_o | output | DATA_W | Bus write-data field |
| cr_ack_i | input | 1 | Acknowledge from PHY |
| cr_rdata_i | input | DATA_W | Read data from PHY |

## Verification
Some rules are checked by assertions on every cycle. The enables never overlap and never rise without select, the address stays stable while select is high, and the clock stays quiet while idle. Done lasts one cycle, timeout only appears with done, and the latched request cannot change mid-access.

The bench's scenarios cover what needs counting across a whole access. It sweeps the ack latency from zero to past the poll limit for both directions and checks the exact pulse totals, the flush length before select, the one-pulse launch window, the read data and register contents, and the rejection of a start while busy.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} pulse_phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FLUSH, S_SEL, S_ARM, S_LAUNCH, S_POLL, S_RETRY, S_GAP
  } seq_state_e;
endpackage

// File: rtl/phy_cr_pulse_gen.sv
module phy_cr_pulse_gen
  import phy_cr_pkg::*;
#(
  parameter int HI_CYC = 1,
  parameter int LO_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic clk_o,
  output logic done_o
);
  localparam int PhMax = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int CW    = (PhMax < 2) ? 1 : $clog2(PhMax + 1);

  pulse_phase_e phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (fire_i) begin
          phase_q <= PH_HIGH;
          cnt_q   <= CW'(HI_CYC - 1);
        end
        PH_HIGH: if (cnt_q == '0) begin
          phase_q <= PH_LOW;
          cnt_q   <= CW'(LO_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_LOW: if (cnt_q == '0) begin
          phase_q <= PH_IDLE;
          done_o  <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign clk_o = (phase_q == PH_HIGH);

  // sequencer must never fire into a pulse in flight
  assert_fire_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> phase_q == PH_IDLE);
  assert_high_then_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HIGH && cnt_q == '0) |=> phase_q == PH_LOW);
endmodule

// File: rtl/phy_cr_seq.sv
module phy_cr_seq
  import phy_cr_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int FLUSH_PULSES = 100,
  parameter int MAX_POLLS    = 10,
  parameter int POLL_GAP     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              pulse_done_i,
  output logic              fire_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sel_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int FW = $clog2(FLUSH_PULSES + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int GW = (POLL_GAP < 2) ? 1 : $clog2(POLL_GAP + 1);

  seq_state_e state_q;
  logic [FW-1:0] flush_q;
  logic [PW-1:0] poll_q;
  logic [GW-1:0] gap_q;
  logic          wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      flush_q   <= '0;
      poll_q    <= '0;
      gap_q     <= '0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      fire_o    <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      rdata_o   <= '0;
      sel_o     <= 1'b0;
      rd_en_o   <= 1'b0;
      wr_en_o   <= 1'b0;
      addr_o    <= '0;
      wdata_o   <= '0;
    end else begin
      fire_o    <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          wr_q    <= write_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          flush_q <= '0;
          fire_o  <= 1'b1;
          state_q <= S_FLUSH;
        end
        S_FLUSH: if (pulse_done_i) begin
          if (flush_q == FW'(FLUSH_PULSES - 1)) state_q <= S_SEL;
          else begin
            flush_q <= flush_q + 1'b1;
            fire_o  <= 1'b1;
          end
        end
        S_SEL: begin
          sel_o   <= 1'b1;
          addr_o  <= addr_q;
          wdata_o <= wr_q ? wdata_q : '0;
          state_q <= S_ARM;
        end
        S_ARM: begin
          wr_en_o <= wr_q;
          rd_en_o <= !wr_q;
          fire_o  <= 1'b1;
          state_q <= S_LAUNCH;
        end
        S_LAUNCH: if (pulse_done_i) begin
          wr_en_o <= 1'b0;
          rd_en_o <= 1'b0;
          poll_q  <= '0;
          state_q <= S_POLL;
        end
        S_POLL: begin
          if (ack_i) begin
            if (!wr_q) rdata_o <= bus_rdata_i;
            done_o  <= 1'b1;
            sel_o   <= 1'b0;
            state_q <= S_IDLE;
          end else if (poll_q == PW'(MAX_POLLS - 1)) begin
            done_o    <= 1'b1;
            timeout_o <= 1'b1;
            sel_o     <= 1'b0;
            state_q   <= S_IDLE;
          end else begin
            fire_o  <= 1'b1;
            state_q <= S_RETRY;
          end
        end
        S_RETRY: if (pulse_done_i) begin
          gap_q   <= GW'(POLL_GAP - 1);
          state_q <= S_GAP;
        end
        S_GAP: begin
          if (gap_q == '0) begin
            poll_q  <= poll_q + 1'b1;
            state_q <= S_POLL;
          end else gap_q <= gap_q - 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);

  // request latches frozen for the whole access
  assert_req_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(addr_q) && $stable(wr_q)));
  assert_poll_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q < PW'(MAX_POLLS));
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int FLUSH_PULSES = 100,
  parameter int MAX_POLLS    = 10,
  parameter int HI_CYC       = 1,
  parameter int LO_CYC       = 1,
  parameter int POLL_GAP     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cr_clk_o,
  output logic              cr_sel_o,
  output logic              cr_rd_en_o,
  output logic              cr_wr_en_o,
  output logic [ADDR_W-1:0] cr_addr_o,
  output logic [DATA_W-1:0] cr_wdata_o,
  input  logic              cr_ack_i,
  input  logic [DATA_W-1:0] cr_rdata_i
);
  logic fire, pulse_done;

  phy_cr_pulse_gen #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) pulse_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .clk_o  (cr_clk_o),
    .done_o (pulse_done)
  );

  phy_cr_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLUSH_PULSES(FLUSH_PULSES),
    .MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP)
  ) seq_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .write_i      (write_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .ack_i        (cr_ack_i),
    .bus_rdata_i  (cr_rdata_i),
    .pulse_done_i (pulse_done),
    .fire_o       (fire),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .timeout_o    (timeout_o),
    .rdata_o      (rdata_o),
    .sel_o        (cr_sel_o),
    .rd_en_o      (cr_rd_en_o),
    .wr_en_o      (cr_wr_en_o),
    .addr_o       (cr_addr_o),
    .wdata_o      (cr_wdata_o)
  );

  assert_idle_clock_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cr_clk_o);
  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_sel_o && $past(cr_sel_o)) |-> $stable(cr_addr_o));
  assert_enables_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cr_rd_en_o && cr_wr_en_o));
  assert_enable_needs_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_rd_en_o || cr_wr_en_o) |-> cr_sel_o);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_timeout_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);
endmodule

// File: tb/phy_cr_master_tb_top.sv
module phy_cr_master_tb_top;
  localparam int HI = 2, LO = 1, GAP = 3, FLUSH = 100, POLLS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic busy, done, tmo;
  logic [15:0] rdata;
  logic cr_clk, cr_sel, cr_rd, cr_wr;
  logic [15:0] cr_addr, cr_wdata, cr_rdata;
  logic cr_ack;

  always #5 clk = ~clk;

  phy_cr_master #(.FLUSH_PULSES(FLUSH), .MAX_POLLS(POLLS), .HI_CYC(HI),
                  .LO_CYC(LO), .POLL_GAP(GAP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr),
    .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done),
    .timeout_o(tmo), .rdata_o(rdata), .cr_clk_o(cr_clk), .cr_sel_o(cr_sel),
    .cr_rd_en_o(cr_rd), .cr_wr_en_o(cr_wr), .cr_addr_o(cr_addr),
    .cr_wdata_o(cr_wdata), .cr_ack_i(cr_ack), .cr_rdata_i(cr_rdata));

  int tests = 0, fails = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // PHY register file model
  logic [15:0] mem [16];
  logic [15:0] rd_latch = '0;
  int pulses = 0, pulses_at_sel = -1, en_pulses = 0, need = 0, ack_cnt = 0;
  bit pending = 0;
  logic [15:0] wdata_at_en = '0;
  int bad_width = 0, idle_clk = 0, run = 0;

  assign cr_rdata = rd_latch;
  assign cr_ack   = pending && (ack_cnt >= need);

  always @(posedge cr_clk) begin
    pulses++;
    if (pending) ack_cnt++;
    if (cr_rd || cr_wr) en_pulses++;
    if (cr_wr) mem[cr_addr[3:0]] = cr_wdata;
    if (cr_rd) rd_latch = mem[cr_addr[3:0]];
  end
  always @(posedge cr_sel) begin
    pulses_at_sel = pulses;
    pending = 0;
  end
  always @(negedge (cr_rd || cr_wr)) begin
    pending = 1;
    ack_cnt = 0;
  end
  always @(posedge cr_wr) wdata_at_en = cr_wdata;
  always @(posedge cr_rd) wdata_at_en = cr_wdata;

  // R1 pulse shape monitor
  always @(negedge clk) begin
    if (cr_clk) run++;
    else begin
      if (run != 0 && run != HI) bad_width++;
      run = 0;
    end
    if (!busy && cr_clk && rst_n) idle_clk++;
  end

  task automatic access(input bit w, input logic [15:0] a, input logic [15:0] d,
                        input int n, input logic [15:0] inj_addr, input bit inject);
    bit exp_to;
    int cyc;
    logic [15:0] exp_rd, old_rd, other_before;
    exp_to = (n >= POLLS);
    exp_rd = mem[a[3:0]];
    old_rd = rdata;
    other_before = mem[inj_addr[3:0]];
    need = n;
    pending = 0;
    @(negedge clk);
    pulses = 0; en_pulses = 0; pulses_at_sel = -1;
    start = 1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    start = 0;
    check(busy === 1'b1, "R9 busy after start", busy, 1);
    check(pulses_at_sel == -1 && !cr_sel, "R2 sel held during flush", cr_sel, 0);
    if (inject) begin
      repeat (20) @(negedge clk);
      start = 1; wr = ~w; addr = inj_addr; wdata = 16'hDEAD;
      @(negedge clk);
      start = 0;
    end
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    check(done === 1'b1, "R9 done seen", done, 1);
    check(busy === 1'b0, "R9 busy low with done", busy, 0);
    check(tmo === exp_to, "R7 timeout flag", tmo, exp_to);
    check(pulses_at_sel == FLUSH, "R2 flush pulses before sel", pulses_at_sel, FLUSH);
    check(pulses == FLUSH + 1 + (exp_to ? POLLS - 1 : n), "R6 total pulses",
          pulses, FLUSH + 1 + (exp_to ? POLLS - 1 : n));
    check(en_pulses == 1, "R5 one pulse under enable", en_pulses, 1);
    check(!cr_sel && !cr_rd && !cr_wr, "R3 sel dropped at done", cr_sel, 0);
    check(cr_addr == a, "R3 address on bus", cr_addr, a);
    check(wdata_at_en == (w ? d : 16'h0), "R4 data at enable rise", wdata_at_en, w ? d : 16'h0);
    if (w && !exp_to) check(mem[a[3:0]] == d, "R5 write landed", mem[a[3:0]], d);
    if (!w && !exp_to) check(rdata == exp_rd, "R8 read data", rdata, exp_rd);
    if (w || exp_to) check(rdata == old_rd, "R8 rdata held", rdata, old_rd);
    if (inject)
      check(mem[inj_addr[3:0]] == other_before, "R10 ignored start no write",
            mem[inj_addr[3:0]], other_before);
    @(negedge clk);
    check(done === 1'b0 && tmo === 1'b0, "R9 done single cycle", done, 0);
    if (inject) begin
      repeat (10) @(negedge clk);
      check(busy === 1'b0, "R10 no second access", busy, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'hA000 + 16'(i * 'h111);
    repeat (3) @(negedge clk);
    check(!busy && !done && !tmo && rdata == 0 && !cr_clk && !cr_sel && !cr_rd &&
          !cr_wr && cr_addr == 0 && cr_wdata == 0, "R11 reset outputs", busy, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    for (int n = 0; n <= POLLS + 1; n++) begin
      access(1'b0, 16'(16'h0100 + n), 16'h0, n, 16'h0, 1'b0);
      access(1'b1, 16'(16'h0200 + n), 16'(16'h5A00 + n * 7), n, 16'h0, 1'b0);
    end
    access(1'b0, 16'h0203, 16'h0, 2, 16'h0, 1'b0); // read-back of earlier write
    access(1'b1, 16'h000E, 16'hBEEF, 1, 16'h000F, 1'b1);
    access(1'b0, 16'h000E, 16'h0, 0, 16'h0009, 1'b1);
    check(bad_width == 0, "R1 pulse high width", bad_width, 0);
    check(idle_clk == 0, "R1 no clock while idle", idle_clk, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule